// File: doc/BRIEF.md
# Double-Precision to Unsigned 64-bit Integer Converter

This unit takes one IEEE-754 binary64 operand and produces the unsigned 64-bit integer it stands for, rounded under one of four modes. Each accepted operand yields a result one clock later, so a new operand may be offered on every cycle. Next to the integer it reports two status bits. One says the value could not be represented. The other says that rounding discarded nonzero fraction bits.

Every binary64 encoding is handled: zeros, subnormals, normals, infinities and NaNs. An out-of-range value gives all ones when the invalid exception is masked. A negative value is legal only when it rounds to zero. The caller picks the rounding mode and handles any trap; this unit only reports.

Top module: `f2u_cvt`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge together with the result and flags for that operand; otherwise `out_valid` is low. While reset is held, `out_valid`, `result` and both flags are 0.
- R2: A non-negative operand that is an integer below 2^64 (including +0 and 2^63) converts exactly, with neither flag set.
- R3: `rnd_mode` 2'b00 rounds to nearest with ties to even (2.5 gives 2, 3.5 gives 4, 2.7 gives 3), and 2'b11 truncates toward zero.
- R4: `rnd_mode` 2'b01 rounds toward minus infinity and 2'b10 toward plus infinity (2.5 gives 2 and 3 respectively).
- R5: An operand with an all-ones exponent field (bits 62:52), NaN or infinity of either sign, always raises invalid.
- R6: The largest binary64 value below 2^64 (2^64-2048) converts exactly. Any operand of 2^64 or more raises invalid.
- R7: A negative operand that rounds to zero returns 0 with only inexact set (-0.5 under 2'b00, -0.4 under 2'b10). Negative zero returns 0 with no flags.
- R8: A negative operand whose rounded magnitude is nonzero raises invalid (-0.6 under 2'b00, -0.4 under 2'b01, -1.0 under any mode).
- R9: When invalid is raised, `result` is all ones if `inv_mask` is 1 and zero if `inv_mask` is 0.
- R10: Inexact is set exactly when nonzero fraction bits are discarded and invalid is not raised. The two flags are never high together.
- R11: A subnormal operand sets inexact. It rounds to 0 under modes 2'b00, 2'b01 and 2'b11, and to 1 under 2'b10 when positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered this cycle |
| operand | input | 64 | binary64 value to convert |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| inv_mask | input | 1 | 1: invalid is masked and returns all ones |
| out_valid | output | 1 | Result for the operand accepted on the previous edge |
| result | output | 64 | Unsigned integer result |
| flag_invalid | output | 1 | Value not representable |
| flag_inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The only state is the output register, so any fault in the datapath shows at the ports on the very next cycle after the operand that excites it. A shift count that is off by one moves the result by a factor of two, or moves a guard bit into the integer. A wrong increment choice shows only on the tie and near-tie operands. Range faults show as a missing or spurious invalid at 2^64-2048 versus 2^64 and at small negatives. The bench streams operands back to back, so a result that is stale or paired with the wrong operand is caught by ordering in the scoreboard.

// File: rtl/f2u_pkg.sv
// Package: shared types and constants for the binary64 to unsigned converter.
// Assumes IEEE-754 field layout: sign at the top, then exponent, then fraction.
package f2u_pkg;

    // Rounding mode codes as seen on the rnd_mode port.
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rnd_e;

endpackage

// File: rtl/f2u_classify.sv
// Module: f2u_classify
// Splits a floating-point word into sign, effective exponent and significand
// with the hidden bit restored. Subnormals get the minimum normal exponent and
// no hidden bit. Assumes EXP_W >= 2.
module f2u_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int FP_W  = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1
) (
    input  logic [FP_W-1:0]  fp_word,
    output logic             sign,
    output logic             special,
    output logic [EXP_W-1:0] exp_eff,
    output logic [SIG_W-1:0] sig
);
    logic [EXP_W-1:0] raw_exp;
    logic             exp_zero;

    // Field extraction and subnormal adjustment.
    always_comb begin
        sign     = fp_word[FP_W-1];
        raw_exp  = fp_word[FP_W-2 -: EXP_W];
        exp_zero = (raw_exp == '0);
        special  = &raw_exp;
        exp_eff  = exp_zero ? EXP_W'(1) : raw_exp;
        sig      = {~exp_zero, fp_word[MAN_W-1:0]};
    end
endmodule

// File: rtl/f2u_align.sv
// Module: f2u_align
// Moves the significand so that its binary point sits below bit 0 of an
// INT_W-bit integer. It reports the integer part, the guard bit, a sticky OR of
// the rest, and whether the magnitude is 2^INT_W or more. Assumes INT_W >= SIG_W.
module f2u_align #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64,
    localparam int SIG_W  = MAN_W + 1,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
    localparam int POINT  = BIAS + MAN_W,
    localparam int E_TOP  = BIAS + INT_W - 1,
    localparam int XW     = EXP_W + 1,
    localparam int SH_W   = $clog2(INT_W),
    localparam int WIDE_W = SIG_W + INT_W
) (
    input  logic [EXP_W-1:0] exp_eff,
    input  logic [SIG_W-1:0] sig,
    output logic [INT_W-1:0] int_part,
    output logic             guard,
    output logic             sticky,
    output logic             too_big
);
    logic [XW-1:0]     exp_x;
    logic [XW-1:0]     rsh_full;
    logic [SH_W-1:0]   rsh;
    logic [SH_W-1:0]   lsh;
    logic [WIDE_W-1:0] wide;
    logic              left_path;

    // Choose shift direction and amount; right shifts are clamped at INT_W-1,
    // which still leaves every significand bit below the guard position.
    always_comb begin
        exp_x     = {1'b0, exp_eff};
        left_path = (exp_x >= XW'(POINT));
        too_big   = (exp_x > XW'(E_TOP));
        lsh       = SH_W'(exp_x - XW'(POINT));
        rsh_full  = XW'(POINT) - exp_x;
        rsh       = (rsh_full > XW'(INT_W - 1)) ? SH_W'(INT_W - 1) : SH_W'(rsh_full);
    end

    // Produce the integer part and the bits that were shifted out.
    always_comb begin
        wide = {sig, {INT_W{1'b0}}} >> rsh;
        if (left_path) begin
            int_part = {{(INT_W-SIG_W){1'b0}}, sig} << lsh;
            guard    = 1'b0;
            sticky   = 1'b0;
        end else begin
            int_part = {{(INT_W-SIG_W){1'b0}}, wide[WIDE_W-1:INT_W]};
            guard    = wide[INT_W-1];
            sticky   = |wide[INT_W-2:0];
        end
    end
endmodule

// File: rtl/f2u_round.sv
// Module: f2u_round
// Applies the rounding increment and the range check. It forms the final
// result and the two flags. Assumes an integer part taken from a right shift is
// below 2^(INT_W-1), so the increment cannot wrap.
module f2u_round #(
    parameter int INT_W = 64
) (
    input  f2u_pkg::rnd_e    mode,
    input  logic             sign,
    input  logic             special,
    input  logic             too_big,
    input  logic [INT_W-1:0] int_part,
    input  logic             guard,
    input  logic             sticky,
    input  logic             inv_mask,
    output logic [INT_W-1:0] value,
    output logic             invalid,
    output logic             inexact
);
    import f2u_pkg::*;

    logic             lost;
    logic             bump;
    logic [INT_W-1:0] mag;

    // Decide whether the magnitude moves up by one ulp.
    always_comb begin
        lost = guard | sticky;
        unique case (mode)
            RM_NEAR: bump = guard & (sticky | int_part[0]);
            RM_DOWN: bump = sign & lost;
            RM_UP:   bump = ~sign & lost;
            default: bump = 1'b0;
        endcase
        mag = int_part + INT_W'(bump);
    end

    // Range check, flag priority and final value.
    always_comb begin
        invalid = special | too_big | (sign & (mag != '0));
        inexact = lost & ~invalid;
        if (invalid)
            value = inv_mask ? {INT_W{1'b1}} : '0;
        else if (sign)
            value = '0;
        else
            value = mag;
    end
endmodule

// File: rtl/f2u_cvt.sv
// Module: f2u_cvt (top)
// Converts one binary64 operand per cycle into an unsigned integer and
// registers the result with its flags. Latency is one clock. The reset is
// synchronous and active low.
module f2u_cvt #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64,
    localparam int FP_W  = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  operand,
    input  logic [1:0]       rnd_mode,
    input  logic             inv_mask,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    import f2u_pkg::*;

    logic             c_sign;
    logic             c_special;
    logic [EXP_W-1:0] c_exp;
    logic [SIG_W-1:0] c_sig;
    logic [INT_W-1:0] a_int;
    logic             a_guard;
    logic             a_sticky;
    logic             a_big;
    logic [INT_W-1:0] r_value;
    logic             r_invalid;
    logic             r_inexact;
    rnd_e             mode;

    // Map the raw mode pins onto the enum.
    always_comb mode = rnd_e'(rnd_mode);

    f2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
        .fp_word (operand),
        .sign    (c_sign),
        .special (c_special),
        .exp_eff (c_exp),
        .sig     (c_sig)
    );

    f2u_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
        .exp_eff  (c_exp),
        .sig      (c_sig),
        .int_part (a_int),
        .guard    (a_guard),
        .sticky   (a_sticky),
        .too_big  (a_big)
    );

    f2u_round #(.INT_W(INT_W)) u_round (
        .mode     (mode),
        .sign     (c_sign),
        .special  (c_special),
        .too_big  (a_big),
        .int_part (a_int),
        .guard    (a_guard),
        .sticky   (a_sticky),
        .inv_mask (inv_mask),
        .value    (r_value),
        .invalid  (r_invalid),
        .inexact  (r_inexact)
    );

    // Output register: capture a result on every accepted operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= r_value;
                flag_invalid <= r_invalid;
                flag_inexact <= r_inexact;
            end
        end
    end

    // R1: an accepted operand produces a result on the next cycle.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no result without an operand.
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: an all-ones exponent always reports invalid.
    p_special_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&operand[FP_W-2 -: EXP_W])) |=> flag_invalid);

    // R9: masked invalid returns all ones.
    p_masked_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_mask) |=> (!flag_invalid || (&result)));

    // R9: unmasked invalid returns zero.
    p_unmasked_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_mask) |=> (!flag_invalid || (result == '0)));

    // R10: the two flags never appear together.
    p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact));

    // R7: a negative operand that is not invalid gives zero.
    p_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[FP_W-1]) |=> (flag_invalid || (result == '0)));
endmodule

// File: tb/f2u_cvt_test.sv
// Scoreboard bench for f2u_cvt: the driver queues expected results and the
// monitor compares them in order as out_valid appears.
module f2u_cvt_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        inv_mask = 1'b1;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid;
    logic        flag_inexact;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [63:0] q_res[$];
    logic        q_inv[$];
    logic        q_inx[$];
    string       q_tag[$];

    f2u_cvt uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .operand      (operand),
        .rnd_mode     (rnd_mode),
        .inv_mask     (inv_mask),
        .out_valid    (out_valid),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: offer one operand per cycle and queue its expected outcome.
    task automatic send(input logic [63:0] op, input logic [1:0] rm, input logic mk,
                        input logic [63:0] er, input logic ei, input logic ex,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        operand  = op;
        rnd_mode = rm;
        inv_mask = mk;
        q_res.push_back(er);
        q_inv.push_back(ei);
        q_inx.push_back(ex);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare each result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tests++;
            if (q_res.size() == 0) begin
                fails++;
                $display("FAIL R1: out_valid with no pending operand, result=%h expected none", result);
            end else begin
                logic [63:0] er;
                logic ei, ex;
                string tg;
                er = q_res.pop_front();
                ei = q_inv.pop_front();
                ex = q_inx.pop_front();
                tg = q_tag.pop_front();
                if (result !== er || flag_invalid !== ei || flag_inexact !== ex) begin
                    fails++;
                    $display("FAIL %s: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                             tg, result, flag_invalid, flag_inexact, er, ei, ex);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || result !== 64'd0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset state got v=%b %h %b %b expected 0 0 0 0",
                     out_valid, result, flag_invalid, flag_inexact);
        end
        rst_n = 1'b1;

        // R2: exact integers.
        send($realtobits(0.0), 2'b00, 1'b1, 64'd0, 1'b0, 1'b0, "R2");
        send($realtobits(1.0), 2'b01, 1'b1, 64'd1, 1'b0, 1'b0, "R2");
        send($realtobits(123456789.0), 2'b10, 1'b1, 64'd123456789, 1'b0, 1'b0, "R2");
        send($realtobits(9007199254740994.0), 2'b00, 1'b1, 64'd9007199254740994, 1'b0, 1'b0, "R2");
        send($realtobits(9223372036854775808.0), 2'b11, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R2");

        // R6: top of range.
        send($realtobits(18446744073709549568.0), 2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R6");
        send($realtobits(18446744073709551616.0), 2'b00, 1'b1, ONES, 1'b1, 1'b0, "R6");
        send($realtobits(18446744073709551616.0), 2'b00, 1'b0, 64'd0, 1'b1, 1'b0, "R6 R9");

        // R3: nearest-even and truncation.
        send($realtobits(2.5), 2'b00, 1'b1, 64'd2, 1'b0, 1'b1, "R3");
        send($realtobits(3.5), 2'b00, 1'b1, 64'd4, 1'b0, 1'b1, "R3");
        send($realtobits(2.7), 2'b00, 1'b1, 64'd3, 1'b0, 1'b1, "R3");
        send($realtobits(0.5), 2'b00, 1'b1, 64'd0, 1'b0, 1'b1, "R3");
        send($realtobits(1.5), 2'b00, 1'b1, 64'd2, 1'b0, 1'b1, "R3");
        send($realtobits(2.7), 2'b11, 1'b1, 64'd2, 1'b0, 1'b1, "R3");
        send($realtobits(2251799813685248.5), 2'b00, 1'b1, 64'd2251799813685248, 1'b0, 1'b1, "R3");

        // R4: directed modes.
        send($realtobits(2.5), 2'b01, 1'b1, 64'd2, 1'b0, 1'b1, "R4");
        send($realtobits(2.5), 2'b10, 1'b1, 64'd3, 1'b0, 1'b1, "R4");
        send($realtobits(2251799813685248.5), 2'b10, 1'b1, 64'd2251799813685249, 1'b0, 1'b1, "R4");

        // R5 and R9: NaN and infinity.
        send(64'h7FF8_0000_0000_0000, 2'b00, 1'b1, ONES, 1'b1, 1'b0, "R5");
        send(64'hFFF8_0000_0000_0001, 2'b11, 1'b1, ONES, 1'b1, 1'b0, "R5");
        send(64'h7FF0_0000_0000_0000, 2'b10, 1'b1, ONES, 1'b1, 1'b0, "R5");
        send(64'hFFF0_0000_0000_0000, 2'b01, 1'b0, 64'd0, 1'b1, 1'b0, "R5 R9");

        // R7: negatives that round to zero.
        send($realtobits(-0.5), 2'b00, 1'b1, 64'd0, 1'b0, 1'b1, "R7");
        send($realtobits(-0.4), 2'b10, 1'b1, 64'd0, 1'b0, 1'b1, "R7");
        send($realtobits(-0.4), 2'b11, 1'b1, 64'd0, 1'b0, 1'b1, "R7");
        send(64'h8000_0000_0000_0000, 2'b01, 1'b1, 64'd0, 1'b0, 1'b0, "R7");

        // R8: negatives with nonzero magnitude.
        send($realtobits(-0.6), 2'b00, 1'b1, ONES, 1'b1, 1'b0, "R8");
        send($realtobits(-0.4), 2'b01, 1'b1, ONES, 1'b1, 1'b0, "R8 R10");
        send($realtobits(-1.0), 2'b11, 1'b0, 64'd0, 1'b1, 1'b0, "R8 R9");

        // R11: subnormals.
        send(64'h0000_0000_0000_0001, 2'b00, 1'b1, 64'd0, 1'b0, 1'b1, "R11");
        send(64'h0000_0000_0000_0001, 2'b10, 1'b1, 64'd1, 1'b0, 1'b1, "R11");
        send(64'h000F_FFFF_FFFF_FFFF, 2'b01, 1'b1, 64'd0, 1'b0, 1'b1, "R11");
        send(64'h8000_0000_0000_0001, 2'b10, 1'b1, 64'd0, 1'b0, 1'b1, "R11");
        send(64'h8000_0000_0000_0001, 2'b01, 1'b1, ONES, 1'b1, 1'b0, "R11 R8");

        // R1: idle gap, then a single operand.
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        send($realtobits(7.0), 2'b00, 1'b1, 64'd7, 1'b0, 1'b0, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        tests++;
        if (q_res.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results missing, expected 0", q_res.size());
        end
        finish_run();
    end
endmodule